// File: doc/BRIEF.md
# Serial Mode Register Interface

This block holds the operating configuration of a converter's output path and power state. Configuration arrives in one of two ways, picked by a static mode pin. In serial mode the four interface pins (active-low select, serial clock, data in, data out) form a slave port. Each access is one 16-bit word that writes a register in a small bank of 8-bit mode registers or reads one back. In parallel mode the same four pins become static straps that directly set the lane count, the power-down state and the output drive current.

All pins are brought into the system clock domain through a synchronizer. Edges of the serial clock are detected there, so the serial clock must be much slower than the system clock. The block drives a set of decoded configuration fields to the downstream formatter and power logic. In serial mode these fields come from the register bank. In parallel mode they come from the straps.

Top module: `modereg_top`

## Requirements
- R1: After reset every register reads 0. The serial-mode fields show code 00 (two lanes) with every flag low, and `sdo_oe` is low.
- R2: A word is sent most significant bit first and is sampled on rising `sck` edges while `csn` is low. Bit 15 is the direction (1 = read, 0 = write), bits 14..8 are the address and bits 7..0 are the data.
- R3: A write takes effect when `csn` rises, and only if at least 16 rising edges arrived during that select period. A shorter write is discarded.
- R4: Rising `sck` edges after the 16th in one select period are ignored. They do not alter the word that is committed.
- R5: During a read, `sdo_oe` goes high on the falling edge that follows the 8th rising edge. `sdo` then shows register bits 7 down to 0, one per falling edge, and shows 0 after the 16th falling edge.
- R6: `sdo_oe` is low whenever `csn` is high and whenever parallel mode is selected.
- R7: A completed write to address 0 clears every register, whatever its data. A read of address 0 returns 0.
- R8: A write to an address of NUM_REGS or above changes nothing. A read of such an address returns 0.
- R9: In serial mode the fields decode as follows.
  - Address 1: bit 0 is sleep and bits 2..1 are nap (channel A, channel B).
  - Address 2: bits 1..0 are the lane code (00 two lanes, 01 four lanes, 10 one lane, 11 unused), bit 2 is half drive current and bit 3 is output off.
  - Address 3: bit 0 is two's complement, bit 1 is scramble and bit 2 is test pattern.
  - All 8 bits of each register read back as written.
- R10: With `par_mode` high the fields follow the straps. The lane code is {`csn`, `sck`}, sleep is `sdi` and half drive current is `sdo_in`. Every other field is 0, whatever the registers hold.
- R11: In parallel mode, activity on the serial pins leaves the registers unchanged. This can be seen after a return to serial mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_mode | input | 1 | 1 = parallel strap mode, 0 = serial mode |
| csn | input | 1 | Active-low select, or lane strap bit 1 |
| sck | input | 1 | Serial clock, or lane strap bit 0 |
| sdi | input | 1 | Serial data in, or sleep strap |
| sdo_in | input | 1 | Data-out pin read as the drive current strap |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for the data-out pin |
| lane_mode | output | 2 | Lane code |
| sleep | output | 1 | Full power-down |
| nap | output | 2 | Per-channel nap (bit 0 channel A) |
| lvds_half | output | 1 | Half output drive current |
| out_off | output | 1 | Output drivers off |
| twos_comp | output | 1 | Two's complement format |
| scramble | output | 1 | Output scrambling |
| test_pat | output | 1 | Test pattern forced |

## Verification
The properties assume that the pins are stable long enough for the synchronizer to see every level. That means the serial clock is much slower than `clk`, and `csn` never changes in the same system cycle as an `sck` edge. The stimulus holds every pin state for eight system clocks and changes one serial pin at a time. The strap pins are changed only while the block is otherwise idle. The outputs are compared only once five cycles have passed since the last pin change, which covers the synchronizer and the register stages.

// File: rtl/modereg_pkg.sv
package modereg_pkg;

    localparam int WORD_W = 16;
    localparam int DATA_W = 8;
    localparam int ADDR_W = WORD_W - DATA_W - 1;
    localparam int HEAD_W = WORD_W - DATA_W;
    localparam int MIN_REGS = 4;

    localparam logic [ADDR_W-1:0] ADDR_CLEAR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_POWER  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_LINK   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADDR_FORMAT = ADDR_W'(3);

    typedef enum logic [1:0] {
        LANES_TWO  = 2'b00,
        LANES_FOUR = 2'b01,
        LANES_ONE  = 2'b10,
        LANES_RSVD = 2'b11
    } lane_e;

    typedef struct packed {
        lane_e      lanes;
        logic       sleep;
        logic [1:0] nap;
        logic       lvds_half;
        logic       out_off;
        logic       twos_comp;
        logic       scramble;
        logic       test_pat;
    } cfg_t;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } word_t;

    function automatic cfg_t cfg_from_regs(input logic [DATA_W-1:0] pwr,
                                           input logic [DATA_W-1:0] link,
                                           input logic [DATA_W-1:0] fmt);
        cfg_t c;
        c.lanes     = lane_e'(link[1:0]);
        c.sleep     = pwr[0];
        c.nap       = pwr[2:1];
        c.lvds_half = link[2];
        c.out_off   = link[3];
        c.twos_comp = fmt[0];
        c.scramble  = fmt[1];
        c.test_pat  = fmt[2];
        return c;
    endfunction

    function automatic cfg_t cfg_from_straps(input logic s_hi, input logic s_lo,
                                             input logic s_pwr, input logic s_cur);
        cfg_t c;
        c           = '0;
        c.lanes     = lane_e'({s_hi, s_lo});
        c.sleep     = s_pwr;
        c.lvds_half = s_cur;
        return c;
    endfunction

endpackage

// File: rtl/modereg_pin_sync.sv
module modereg_pin_sync #(
    parameter int               WIDTH     = 5,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= RESET_VAL;
                else     stg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= {STAGES{RESET_VAL}};
                else     stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/modereg_serial_engine.sv
module modereg_serial_engine
    import modereg_pkg::*;
#(
    parameter  int WORD_BITS = WORD_W,
    parameter  int DATA_BITS = DATA_W,
    localparam int CNT_W     = $clog2(WORD_BITS + 1),
    localparam int HEAD_BITS = WORD_BITS - DATA_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 cs_n,
    input  logic                 sck,
    input  logic                 sdi,
    input  logic [DATA_BITS-1:0] rd_data,
    output logic [WORD_BITS-1:0] word,
    output logic [CNT_W-1:0]     bit_cnt,
    output logic                 commit,
    output logic                 sdo,
    output logic                 sdo_oe
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_BITS);
    localparam logic [CNT_W-1:0] HEAD = CNT_W'(HEAD_BITS);

    logic                 sck_q, cs_q;
    logic                 rise, fall, cs_rise, active;
    logic [DATA_BITS-1:0] out_sh;

    assign rise    = sck & ~sck_q;
    assign fall    = ~sck & sck_q;
    assign cs_rise = cs_n & ~cs_q;
    assign active  = enable & ~cs_n;
    assign commit  = enable & cs_rise & (bit_cnt == FULL);
    assign sdo     = sdo_oe & out_sh[DATA_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            bit_cnt <= '0;
            word    <= '0;
            out_sh  <= '0;
            sdo_oe  <= 1'b0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (!active) begin
                bit_cnt <= '0;
                out_sh  <= '0;
                sdo_oe  <= 1'b0;
            end else begin
                if (rise && bit_cnt < FULL) begin
                    word    <= {word[WORD_BITS-2:0], sdi};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (fall) begin
                    if (bit_cnt == HEAD) begin
                        out_sh <= rd_data;
                        sdo_oe <= word[HEAD_BITS-1];
                    end else if (bit_cnt > HEAD) begin
                        out_sh <= {out_sh[DATA_BITS-2:0], 1'b0};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/modereg_reg_bank.sv
module modereg_reg_bank
    import modereg_pkg::*;
#(
    parameter  int NUM_REGS = MIN_REGS,
    localparam int FLAT_W   = NUM_REGS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [WORD_W-1:0] word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [FLAT_W-1:0] regs_flat
);

    word_t w;
    logic  wr_ok, clear_all;

    assign w         = word_t'(word);
    assign wr_ok     = commit & ~w.rd;
    assign clear_all = wr_ok & (w.addr == ADDR_CLEAR);

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            if (i == 0) begin : g_clear_slot
                assign regs_flat[i*DATA_W +: DATA_W] = '0;
            end else begin : g_store
                logic [DATA_W-1:0] q;
                always_ff @(posedge clk) begin
                    if (rst || clear_all)
                        q <= '0;
                    else if (wr_ok && w.addr == ADDR_W'(i))
                        q <= w.data;
                end
                assign regs_flat[i*DATA_W +: DATA_W] = q;
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = regs_flat[i*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/modereg_top.sv
module modereg_top
    import modereg_pkg::*;
#(
    parameter int NUM_REGS    = MIN_REGS,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       par_mode,
    input  logic       csn,
    input  logic       sck,
    input  logic       sdi,
    input  logic       sdo_in,
    output logic       sdo,
    output logic       sdo_oe,
    output logic [1:0] lane_mode,
    output logic       sleep,
    output logic [1:0] nap,
    output logic       lvds_half,
    output logic       out_off,
    output logic       twos_comp,
    output logic       scramble,
    output logic       test_pat
);

    localparam int FLAT_W = NUM_REGS * DATA_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    logic [4:0]        pins_s;
    logic              par_s, cs_s, sck_s, sdi_s, sdoin_s;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  bit_cnt;
    logic              commit;
    logic [DATA_W-1:0] rd_data;
    logic [FLAT_W-1:0] regs_flat;
    cfg_t              cfg_serial, cfg_par, cfg;

    modereg_pin_sync #(
        .WIDTH    (5),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(5'b01000)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({par_mode, csn, sck, sdi, sdo_in}),
        .q  (pins_s)
    );

    assign {par_s, cs_s, sck_s, sdi_s, sdoin_s} = pins_s;

    modereg_serial_engine #(
        .WORD_BITS(WORD_W),
        .DATA_BITS(DATA_W)
    ) u_engine (
        .clk    (clk),
        .rst    (rst),
        .enable (~par_s),
        .cs_n   (cs_s),
        .sck    (sck_s),
        .sdi    (sdi_s),
        .rd_data(rd_data),
        .word   (word),
        .bit_cnt(bit_cnt),
        .commit (commit),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );

    modereg_reg_bank #(
        .NUM_REGS(NUM_REGS)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .word     (word),
        .rd_addr  (word[ADDR_W-1:0]),
        .rd_data  (rd_data),
        .regs_flat(regs_flat)
    );

    assign cfg_serial = cfg_from_regs(regs_flat[int'(ADDR_POWER)*DATA_W +: DATA_W],
                                      regs_flat[int'(ADDR_LINK)*DATA_W +: DATA_W],
                                      regs_flat[int'(ADDR_FORMAT)*DATA_W +: DATA_W]);
    assign cfg_par    = cfg_from_straps(cs_s, sck_s, sdi_s, sdoin_s);
    assign cfg        = par_s ? cfg_par : cfg_serial;

    assign lane_mode = cfg.lanes;
    assign sleep     = cfg.sleep;
    assign nap       = cfg.nap;
    assign lvds_half = cfg.lvds_half;
    assign out_off   = cfg.out_off;
    assign twos_comp = cfg.twos_comp;
    assign scramble  = cfg.scramble;
    assign test_pat  = cfg.test_pat;

endmodule

// File: rtl/modereg_checker.sv
module modereg_checker
    import modereg_pkg::*;
#(
    parameter  int NUM_REGS = MIN_REGS,
    localparam int FLAT_W   = NUM_REGS * DATA_W,
    localparam int CNT_W    = $clog2(WORD_W + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_s,
    input logic              sck_s,
    input logic              par_s,
    input logic              sdo_oe,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [WORD_W-1:0] word,
    input logic              commit,
    input logic [FLAT_W-1:0] regs
);

    assert_short_drop_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(cs_s) && bit_cnt != CNT_W'(WORD_W)) |=> $stable(regs));

    assert_extra_edge_R4: assert property (@(posedge clk) disable iff (rst)
        (!par_s && !cs_s && $rose(sck_s) && bit_cnt == CNT_W'(WORD_W)) |=> $stable(word));

    assert_oe_start_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> (bit_cnt == CNT_W'(HEAD_W)));

    assert_oe_cs_high_R6: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> !sdo_oe);

    assert_oe_parallel_R6: assert property (@(posedge clk) disable iff (rst)
        par_s |=> !sdo_oe);

    assert_soft_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (commit && word[WORD_W-1:DATA_W] == '0) |=> (regs == '0));

    assert_bad_addr_R8: assert property (@(posedge clk) disable iff (rst)
        (commit && word[WORD_W-2:DATA_W] >= ADDR_W'(NUM_REGS)) |=> $stable(regs));

    assert_par_hold_R11: assert property (@(posedge clk) disable iff (rst)
        par_s |=> $stable(regs));

endmodule

bind modereg_top modereg_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_s   (cs_s),
    .sck_s  (sck_s),
    .par_s  (par_s),
    .sdo_oe (sdo_oe),
    .bit_cnt(bit_cnt),
    .word   (word),
    .commit (commit),
    .regs   (regs_flat)
);

// File: tb/modereg_top_test.sv
module modereg_top_test;

    localparam int NREG   = 4;
    localparam int HOLD   = 8;
    localparam int SETTLE = 6;
    localparam int LIMIT  = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic par_mode = 1'b0, csn = 1'b1, sck = 1'b0, sdi = 1'b0, sdo_in = 1'b0;
    logic sdo, sdo_oe, sleep, lvds_half, out_off, twos_comp, scramble, test_pat;
    logic [1:0] lane_mode, nap;

    modereg_top #(.NUM_REGS(NREG), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .par_mode(par_mode), .csn(csn), .sck(sck),
        .sdi(sdi), .sdo_in(sdo_in), .sdo(sdo), .sdo_oe(sdo_oe),
        .lane_mode(lane_mode), .sleep(sleep), .nap(nap), .lvds_half(lvds_half),
        .out_off(out_off), .twos_comp(twos_comp), .scramble(scramble),
        .test_pat(test_pat)
    );

    int checks = 0, errors = 0, settle = 0, cycles = 0;
    bit watching = 1'b0;
    logic [7:0] mregs [NREG];
    logic       exp_oe = 1'b0, exp_sdo = 1'b0;
    logic [7:0] rd_val = '0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_cfg();
        if (par_mode) return {csn, sck, sdi, 2'b00, sdo_in, 4'b0000};
        return {mregs[2][1:0], mregs[1][0], mregs[1][2:1], mregs[2][2], mregs[2][3],
                mregs[3][0], mregs[3][1], mregs[3][2]};
    endfunction

    function automatic logic [9:0] act_cfg();
        return {lane_mode, sleep, nap, lvds_half, out_off, twos_comp, scramble, test_pat};
    endfunction

    function automatic logic [7:0] model_read(input logic [6:0] a);
        if (a == 0 || a >= NREG) return 8'h00;
        return mregs[a];
    endfunction

    always @(negedge clk) begin
        cycles++;
        if (watching && settle >= SETTLE) begin
            check(act_cfg() == exp_cfg(), par_mode ? "R10 strap fields" : "R9 register fields",
                  int'(act_cfg()), int'(exp_cfg()));
            check(sdo_oe == exp_oe, "R5 R6 output enable", int'(sdo_oe), int'(exp_oe));
            if (exp_oe) check(sdo == exp_sdo, "R5 read bit", int'(sdo), int'(exp_sdo));
        end
        settle = settle + 1;
        if (cycles > LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic drive(input logic c, input logic s, input logic d);
        @(posedge clk);
        #1;
        csn = c; sck = s; sdi = d;
        settle = 0;
    endtask

    task automatic hold();
        repeat (HOLD) @(posedge clk);
    endtask

    task automatic set_mode(input logic p, input logic strap_cur);
        @(posedge clk);
        #1;
        par_mode = p; sdo_in = strap_cur;
        settle = 0;
        hold();
    endtask

    task automatic fall_update(input int r, input logic [15:0] w);
        if (par_mode) return;
        if (r == 8 && w[15]) begin
            exp_oe  = 1'b1;
            rd_val  = model_read(w[14:8]);
            exp_sdo = rd_val[7];
        end else if (exp_oe) begin
            exp_sdo = (r < 16) ? rd_val[15-r] : 1'b0;
        end
    endtask

    task automatic xfer(input logic [15:0] w, input int n, output logic [7:0] cap);
        cap = '0;
        drive(1'b0, 1'b0, 1'b0);
        hold();
        for (int k = 0; k < n; k++) begin
            logic b;
            b = (k < 16) ? w[15-k] : k[0];
            drive(1'b0, 1'b0, b);
            if (k > 0) fall_update(k, w);
            hold();
            if (k >= 8 && k <= 15) cap[15-k] = sdo;
            drive(1'b0, 1'b1, b);
            hold();
        end
        drive(1'b0, 1'b0, 1'b0);
        if (n > 0) fall_update(n, w);
        hold();
        if (n >= 8 && n <= 15) cap[15-n] = sdo;
        drive(1'b1, 1'b0, 1'b0);
        exp_oe = 1'b0;
        exp_sdo = 1'b0;
        if (!par_mode && n >= 16 && !w[15]) begin
            if (w[14:8] == 0) begin
                for (int i = 0; i < NREG; i++) mregs[i] = 8'h00;
            end else if (w[14:8] < NREG) begin
                mregs[w[14:8]] = w[7:0];
            end
        end
        hold();
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] c;
        xfer({1'b0, a, d}, 16, c);
    endtask

    task automatic rd_check(input logic [6:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] c;
        xfer({1'b1, a, 8'h00}, 16, c);
        check(c == exp, tag, int'(c), int'(exp));
    endtask

    initial begin
        logic [7:0] junk;
        for (int i = 0; i < NREG; i++) mregs[i] = 8'h00;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        hold();
        watching = 1'b1;

        // R1: reset state
        check(act_cfg() == 10'd0, "R1 fields after reset", int'(act_cfg()), 0);
        check(sdo_oe == 1'b0, "R1 oe after reset", int'(sdo_oe), 0);
        rd_check(7'd2, 8'h00, "R1 register readback after reset");

        // R2 R9: writes and decoded fields
        wr(7'd2, 8'h0D);
        check(lane_mode == 2'b01, "R2 R9 lane code four", int'(lane_mode), 1);
        check({lvds_half, out_off} == 2'b11, "R9 link flags", int'({lvds_half, out_off}), 3);
        wr(7'd1, 8'h07);
        check({sleep, nap} == 3'b111, "R9 power fields", int'({sleep, nap}), 7);
        wr(7'd3, 8'hA5);
        check({twos_comp, scramble, test_pat} == 3'b101, "R9 format fields",
              int'({twos_comp, scramble, test_pat}), 5);

        // R5: readback of every bit
        rd_check(7'd3, 8'hA5, "R5 read format register");
        rd_check(7'd2, 8'h0D, "R5 read link register");
        rd_check(7'd1, 8'h07, "R5 read power register");

        // R3: short write discarded
        xfer({1'b0, 7'd2, 8'h02}, 15, junk);
        check(lane_mode == 2'b01, "R3 short write ignored", int'(lane_mode), 1);
        rd_check(7'd2, 8'h0D, "R3 register kept after short write");

        // R4: extra edges ignored
        xfer({1'b0, 7'd2, 8'h02}, 21, junk);
        check(lane_mode == 2'b10, "R4 write with extra edges", int'(lane_mode), 2);
        rd_check(7'd2, 8'h02, "R4 committed word unaffected");
        xfer({1'b1, 7'd3, 8'h00}, 20, junk);
        check(junk == 8'hA5, "R4 read with extra edges", int'(junk), 8'hA5);

        // R8: out-of-range address
        wr(7'h45, 8'hFF);
        rd_check(7'h45, 8'h00, "R8 unmapped read");
        rd_check(7'd3, 8'hA5, "R8 mapped register kept");

        // R7: soft clear
        rd_check(7'd0, 8'h00, "R7 address zero reads zero");
        wr(7'd0, 8'h00);
        check(act_cfg() == 10'd0, "R7 fields cleared", int'(act_cfg()), 0);
        rd_check(7'd3, 8'h00, "R7 format register cleared");
        rd_check(7'd1, 8'h00, "R7 power register cleared");

        // R10: parallel straps
        wr(7'd2, 8'h0D);
        wr(7'd3, 8'h07);
        set_mode(1'b1, 1'b1);
        for (int code = 0; code < 4; code++) begin
            drive(code[1], code[0], code[0]);
            hold();
            check(lane_mode == code[1:0], "R10 strap lane code", int'(lane_mode), code);
            check(sleep == code[0], "R10 strap sleep", int'(sleep), code & 1);
            check(lvds_half == 1'b1, "R10 strap current", int'(lvds_half), 1);
            check({nap, out_off, twos_comp, scramble, test_pat} == 6'd0,
                  "R10 other fields zero", int'({nap, out_off, twos_comp, scramble, test_pat}), 0);
        end

        // R6 R11: serial activity in parallel mode
        xfer({1'b1, 7'd2, 8'h00}, 16, junk);
        check(sdo_oe == 1'b0, "R6 oe low in parallel", int'(sdo_oe), 0);
        xfer({1'b0, 7'd2, 8'h00}, 16, junk);
        xfer({1'b0, 7'd0, 8'h00}, 16, junk);
        set_mode(1'b0, 1'b0);
        check(lane_mode == 2'b01, "R11 lane kept after parallel", int'(lane_mode), 1);
        rd_check(7'd2, 8'h0D, "R11 link register kept");
        rd_check(7'd3, 8'h07, "R11 format register kept");
        check(sdo_oe == 1'b0, "R6 oe low with select high", int'(sdo_oe), 0);

        hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule